// File: doc/BRIEF.md
# Phase-Multiplexed Shared RAM Controller

This block lets two independent requesters work from one synchronous single-port RAM. They take turns, and the turns are set by two phase strobes from outside the block. Each requester has its own select, read/write line, address, write data and read data. When a requester's phase strobe is high at a clock rising edge, the block samples that requester's request and carries it out on the shared RAM port in that same edge.

A read follows a fixed path. The RAM output register captures the word at the sampling edge. At the next edge the word moves into that requester's private read-data register, and a one-cycle valid pulse marks the update. The read-data registers change only when a read returns to them. The other requester's traffic therefore never disturbs a held result.

The phase strobes normally alternate, and idle gaps between them are allowed. A, B, A, B on consecutive edges runs with no dead cycles. If both strobes are high together, requester A is served, requester B's request is discarded, and a collision flag is high for that cycle.

Top module: `phram_ctrl`

## Requirements
- R1: A requester's select, read/write, address and write data are ignored at any edge where its phase strobe is low. No RAM access follows from them.
- R2: A read is a sampled request with select=1 and rnw=1. At the edge after the sampling edge, that requester's read-data register takes the addressed word, and its valid output is high for exactly the one following cycle.
- R3: A write is a sampled request with select=1 and rnw=0. The RAM word is committed at the sampling edge, and a later read of that address returns the written data.
- R4: A write leaves the writing requester's read-data register and valid output unchanged.
- R5: If a requester's select is 0 at its phase edge, no access is made, its read data holds and no valid pulse follows.
- R6: A requester's read-data register holds its value while the other requester reads and writes the RAM.
- R7: Requests alternating A, B, A, B on consecutive edges are all served, and each read returns its own address's data.
- R8: If both phase strobes are high in the same cycle, requester A is served and requester B's request has no effect (no write, no valid pulse). The collision output is high for that cycle only.
- R9: A synchronous active-low reset clears both read-data registers and both valid outputs. RAM contents are not cleared.
- R10: Suppose a read for one requester is returning while the other requester writes the same address at that edge. The returned word is the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_phase | input | 1 | Slot strobe for requester A |
| a_sel | input | 1 | Requester A select |
| a_rnw | input | 1 | Requester A: 1 read, 0 write |
| a_addr | input | ADDR_W | Requester A address |
| a_wdata | input | DATA_W | Requester A write data |
| a_rdata | output | DATA_W | Requester A registered read data |
| a_rvalid | output | 1 | Requester A read-data update pulse |
| b_phase | input | 1 | Slot strobe for requester B |
| b_sel | input | 1 | Requester B select |
| b_rnw | input | 1 | Requester B: 1 read, 0 write |
| b_addr | input | ADDR_W | Requester B address |
| b_wdata | input | DATA_W | Requester B write data |
| b_rdata | output | DATA_W | Requester B registered read data |
| b_rvalid | output | 1 | Requester B read-data update pulse |
| collide | output | 1 | Both phase strobes high this cycle |

## Verification
Two functions can land on the same edge. One is the return of a read into one requester's register; the other is a new access, a write to the same address, by the other requester. The bench provokes this by issuing a read for A and then, on the very next edge, a B write to that address. It then checks that A receives the old word and that a later read sees the new one. The second overlap is a collision. Both strobes are raised together, with writes and with a B read. The collision flag, the untouched B target word and the missing B valid pulse are checked.

// File: rtl/phram_pkg.sv
// Package: shared types for the phase-multiplexed RAM controller.
// Assumes: exactly two requesters; index 0 is A, 1 is B.
package phram_pkg;
    typedef enum logic {
        REQ_A = 1'b0,
        REQ_B = 1'b1
    } req_id_e;

    localparam int NUM_REQ = 2;
endpackage

// File: rtl/phram_slot_sel.sv
// Module: selects which requester drives the RAM port this edge and tracks
// the pending read return.
// Assumes: phase strobes alternate; if both are high, requester A wins.
module phram_slot_sel
    import phram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        phase,
    input  logic [1:0]        sel,
    input  logic [1:0]        rnw,
    input  logic [ADDR_W-1:0] addr  [NUM_REQ],
    input  logic [DATA_W-1:0] wdata [NUM_REQ],
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ret_valid,
    output req_id_e           ret_id,
    output logic              collide
);
    logic    slot_hit;
    req_id_e slot_id;

    // Priority pick: scan from the highest index down so that A overrides.
    always_comb begin
        slot_hit = 1'b0;
        slot_id  = REQ_A;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (phase[i]) begin
                slot_hit = 1'b1;
                slot_id  = req_id_e'(i[0]);
            end
        end
    end

    // Drive the shared RAM port from the chosen requester.
    always_comb begin
        ram_en    = slot_hit && sel[slot_id];
        ram_we    = ram_en && !rnw[slot_id];
        ram_addr  = addr[slot_id];
        ram_wdata = wdata[slot_id];
    end

    // Collision flag: both strobes in one cycle.
    assign collide = phase[0] && phase[1];

    // Return tracker: a read issued now comes back at the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_valid <= 1'b0;
            ret_id    <= REQ_A;
        end else begin
            ret_valid <= ram_en && !ram_we;
            ret_id    <= slot_id;
        end
    end

    assert_off_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b00) |-> !ram_en);

    assert_drop_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11 && !sel[0]) |-> !ram_en);
endmodule

// File: rtl/phram_spram.sv
// Module: single-port synchronous RAM with a registered read output.
// Assumes: one access per edge; a write does not update the read output.
module phram_spram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array access: write or registered read, never both.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    q         <= mem[addr];
        end
    end
endmodule

// File: rtl/phram_hold.sv
// Module: per-requester read-data register with a one-cycle update pulse.
// Assumes: loads only when the pending return is tagged with MY_ID.
module phram_hold
    import phram_pkg::*;
#(
    parameter int      DATA_W = 16,
    parameter req_id_e MY_ID  = REQ_A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  req_id_e           ret_id,
    input  logic [DATA_W-1:0] ram_q,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic take;
    assign take = ret_valid && (ret_id == MY_ID);

    // Hold register: capture RAM output on own return, else keep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= take;
            if (take) rdata <= ram_q;
        end
    end
endmodule

// File: rtl/phram_ctrl.sv
// Module: top of the phase-multiplexed shared RAM controller.
// Assumes: external phase strobes grant slots; read results land one edge
// after the sampling edge and are held until the next read return.
module phram_ctrl
    import phram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_phase,
    input  logic              a_sel,
    input  logic              a_rnw,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    input  logic              b_phase,
    input  logic              b_sel,
    input  logic              b_rnw,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid,
    output logic              collide
);
    logic [ADDR_W-1:0] req_addr  [NUM_REQ];
    logic [DATA_W-1:0] req_wdata [NUM_REQ];
    logic [DATA_W-1:0] out_data  [NUM_REQ];
    logic [1:0]        out_vld;

    logic              ram_en, ram_we, ret_valid;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata, ram_q;
    req_id_e           ret_id;

    // Gather the flat ports into indexed form.
    always_comb begin
        req_addr[0]  = a_addr;
        req_addr[1]  = b_addr;
        req_wdata[0] = a_wdata;
        req_wdata[1] = b_wdata;
    end

    phram_slot_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) slot_i (
        .clk(clk), .rst_n(rst_n),
        .phase({b_phase, a_phase}), .sel({b_sel, a_sel}), .rnw({b_rnw, a_rnw}),
        .addr(req_addr), .wdata(req_wdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ret_valid(ret_valid), .ret_id(ret_id),
        .collide(collide)
    );

    phram_spram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .q(ram_q)
    );

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_hold
        phram_hold #(.DATA_W(DATA_W), .MY_ID(req_id_e'(g))) hold_i (
            .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_id(ret_id),
            .ram_q(ram_q), .rdata(out_data[g]), .rvalid(out_vld[g])
        );
    end

    assign a_rdata  = out_data[0];
    assign b_rdata  = out_data[1];
    assign a_rvalid = out_vld[0];
    assign b_rvalid = out_vld[1];

    assert_hold_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !a_rvalid |-> $stable(a_rdata));

    assert_hold_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !b_rvalid |-> $stable(b_rdata));

    assert_ret_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        a_rvalid |-> $past(a_phase && a_sel && a_rnw, 2));

    assert_ret_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        b_rvalid |-> $past(b_phase && b_sel && b_rnw && !a_phase, 2));

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (a_rdata == '0 && b_rdata == '0 && !a_rvalid && !b_rvalid));
endmodule

// File: tb/phram_ctrl_tb_top.sv
`timescale 1ns/1ps
module phram_ctrl_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NV = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_phase = 0, a_sel = 0, a_rnw = 1, b_phase = 0, b_sel = 0, b_rnw = 1;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic a_rvalid, b_rvalid, collide;

    int n_run = 0, n_fail = 0;
    logic [DW-1:0] exp_a = '0, exp_b = '0;

    always #2 clk = ~clk;

    phram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

    // Vector layout: {port(1: B), rnw(1), addr(8), data(16)}; reads expect data.
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h05, 16'h1234},
        {1'b1, 1'b0, 8'h06, 16'hABCD},
        {1'b0, 1'b1, 8'h06, 16'hABCD},
        {1'b1, 1'b1, 8'h05, 16'h1234},
        {1'b1, 1'b0, 8'hFF, 16'h00FF},
        {1'b0, 1'b0, 8'h00, 16'hFFFF},
        {1'b0, 1'b1, 8'hFF, 16'h00FF},
        {1'b1, 1'b1, 8'h00, 16'hFFFF},
        {1'b0, 1'b0, 8'h05, 16'h5555},
        {1'b1, 1'b1, 8'h05, 16'h5555}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_all();
        a_phase = 0; a_sel = 0; a_rnw = 1;
        b_phase = 0; b_sel = 0; b_rnw = 1;
    endtask

    // Drive one request at a negedge; it is sampled at the next posedge.
    task automatic drive(input logic port, input logic rnw, input logic [AW-1:0] ad,
                         input logic [DW-1:0] wd);
        if (!port) begin
            a_phase = 1; a_sel = 1; a_rnw = rnw; a_addr = ad; a_wdata = wd;
        end else begin
            b_phase = 1; b_sel = 1; b_rnw = rnw; b_addr = ad; b_wdata = wd;
        end
    endtask

    // Single isolated access; for reads, check the result after the return edge.
    task automatic single(input logic port, input logic rnw, input logic [AW-1:0] ad,
                          input logic [DW-1:0] d, input string req);
        @(negedge clk); drive(port, rnw, ad, d);
        @(negedge clk); clear_all();
        @(negedge clk);
        if (rnw) begin
            if (!port) begin
                exp_a = d;
                check({req, " A rdata"}, a_rdata, exp_a);
                check({req, " A rvalid"}, a_rvalid, 1);
            end else begin
                exp_b = d;
                check({req, " B rdata"}, b_rdata, exp_b);
                check({req, " B rvalid"}, b_rvalid, 1);
            end
        end else begin
            check("R4 no valid on write", {a_rvalid, b_rvalid}, 0);
        end
        check("R6 other A held", a_rdata, exp_a);
        check("R6 other B held", b_rdata, exp_b);
        @(negedge clk);
        check("R2 valid one cycle", {a_rvalid, b_rvalid}, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset A rdata", a_rdata, 0);
        check("R9 reset B rdata", b_rdata, 0);
        check("R9 reset valids", {a_rvalid, b_rvalid}, 0);
        rst_n = 1;

        // Table walk: writes, reads, address extremes, overwrite (R2 R3 R4 R6).
        for (int i = 0; i < NV; i++)
            single(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:0],
                   VEC[i][24] ? "R2/R3 read" : "R3 write");

        // R7: seed four words, then A,B,A,B reads on consecutive edges.
        for (int i = 0; i < 4; i++) single(1'b0, 1'b0, 8'h10 + 8'(i), 16'hC000 + 16'(i), "R3 seed");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                if (i % 2 == 0) begin
                    check("R7 A data", a_rdata, 16'hC000 + 16'(i - 2));
                    check("R7 A valid", a_rvalid, 1);
                end else begin
                    check("R7 B data", b_rdata, 16'hC000 + 16'(i - 2));
                    check("R7 B valid", b_rvalid, 1);
                    check("R6 A held during B", a_rdata, 16'hC000 + 16'(i - 3));
                end
            end
            clear_all();
            if (i < 4) drive(i[0], 1'b1, 8'h10 + 8'(i), '0);
        end
        exp_a = 16'hC002; exp_b = 16'hC003;

        // R10: A reads addr 0x30, B writes it on the next edge.
        single(1'b0, 1'b0, 8'h30, 16'h3030, "R3 seed");
        @(negedge clk); drive(1'b0, 1'b1, 8'h30, '0);
        @(negedge clk); clear_all(); drive(1'b1, 1'b0, 8'h30, 16'h4040);
        @(negedge clk); clear_all();
        check("R10 old word returned", a_rdata, 16'h3030);
        exp_a = 16'h3030;
        single(1'b0, 1'b1, 8'h30, 16'h4040, "R10 new word later");

        // R8: both strobes with writes; A wins, B target untouched.
        single(1'b1, 1'b0, 8'h21, 16'hAAAA, "R3 seed");
        @(negedge clk);
        drive(1'b0, 1'b0, 8'h20, 16'h1111); drive(1'b1, 1'b0, 8'h21, 16'h2222);
        #1 check("R8 collide high", collide, 1);
        @(negedge clk); clear_all();
        #1 check("R8 collide one cycle", collide, 0);
        single(1'b1, 1'b1, 8'h21, 16'hAAAA, "R8 B write dropped");
        single(1'b0, 1'b1, 8'h20, 16'h1111, "R8 A write served");
        // R8: both strobes, A idle, B read: no B return.
        @(negedge clk);
        a_phase = 1; a_sel = 0; drive(1'b1, 1'b1, 8'h20, '0);
        @(negedge clk); clear_all();
        @(negedge clk);
        check("R8 no B valid", b_rvalid, 0);
        check("R8 B rdata held", b_rdata, exp_b);

        // R1: request with phase low is ignored.
        @(negedge clk);
        a_sel = 1; a_rnw = 0; a_addr = 8'h20; a_wdata = 16'hDEAD;
        @(negedge clk); clear_all();
        @(negedge clk);
        check("R1 no valid off-phase", {a_rvalid, b_rvalid}, 0);
        single(1'b0, 1'b1, 8'h20, 16'h1111, "R1 word unchanged");

        // R5: phase with select low: no access, data held.
        @(negedge clk); a_phase = 1; a_sel = 0; a_rnw = 1; a_addr = 8'h05;
        @(negedge clk); clear_all();
        @(negedge clk);
        check("R5 no valid", a_rvalid, 0);
        check("R5 rdata held", a_rdata, 16'h1111);

        // R9: mid-run reset clears held data.
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        check("R9 mid reset A", a_rdata, 0);
        check("R9 mid reset B", b_rdata, 0);
        rst_n = 1;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule